// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Flags

This block buffers characters that come from a serial receiver until the CPU reads them. Each slot keeps the 8-bit character and three flags: parity error, framing error and break. The CPU sees the oldest character on `rd_data`. A single-cycle `rd_en` pulse removes that character and its flags together.

Two status views are offered. In per-character mode, the error outputs show the flags of the character at the head of the queue. In accumulated mode, each error output is the OR of that flag over every character accepted since the last error-reset command. A sticky overrun flag records that a character was lost because the queue was full. The interrupt output follows either the ready condition or the full condition, chosen by a select input. The depth is a parameter, 8 or 16.

Top module: `rx_status_fifo`

## Requirements
- R1: After reset the queue is empty, and `ready`, `full`, all three status outputs, `overrun` and `irq` are 0.
- R2: `ready` is 1 exactly when at least one character is held. `full` is 1 exactly when DEPTH characters are held.
- R3: `rd_data` shows the oldest held character. An `rd_en` cycle with `ready`=1 removes that character together with its flags. An `rd_en` cycle on an empty queue has no effect.
- R4: With `block_mode`=0, `stat_perr`, `stat_ferr` and `stat_brk` equal the flags stored with the head character while `ready`=1, and are 0 while the queue is empty.
- R5: With `block_mode`=1, each status output is the OR of that flag over all characters accepted since the last `err_reset` or reset, shown only while `ready`=1. A character accepted in the same cycle as `err_reset` starts the new accumulation.
- R6: A `wr_en` cycle with `full`=1 and no `rd_en` sets `overrun`, discards the incoming character and leaves the stored characters unchanged.
- R7: `overrun` stays set until an `err_reset` cycle. If a new overrun occurs in the same cycle as `err_reset`, `overrun` stays set.
- R8: `wr_en` and `rd_en` in the same cycle while full pops the head, stores the new character, keeps `full`=1 and does not set `overrun`.
- R9: `irq` equals `ready` when `irq_sel_full`=0 and equals `full` when `irq_sel_full`=1.
- R10: A `rcv_reset` cycle empties the queue. It takes priority over a write or read in the same cycle, and it neither sets nor clears `overrun` or the accumulated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rcv_reset | input | 1 | Empty the queue |
| err_reset | input | 1 | Clear overrun and the accumulated flags |
| block_mode | input | 1 | 0: per-character status, 1: accumulated status |
| irq_sel_full | input | 1 | 0: irq follows ready, 1: irq follows full |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error flag of the character |
| wr_ferr | input | 1 | Framing error flag of the character |
| wr_brk | input | 1 | Break flag of the character |
| rd_en | input | 1 | CPU read; pops the head |
| rd_data | output | 8 | Head character |
| ready | output | 1 | At least one character held |
| full | output | 1 | All slots held |
| stat_perr | output | 1 | Reported parity error |
| stat_ferr | output | 1 | Reported framing error |
| stat_brk | output | 1 | Reported break |
| overrun | output | 1 | Sticky character-loss flag |
| irq | output | 1 | Interrupt source |

## Verification
Two things can happen in the same cycle: a receiver write and a CPU read while the queue is full. The result decides whether the character is accepted or counted as an overrun. The bench fills the queue, then drives write and read together and also a write alone. It compares occupancy, head data and the overrun flag against a reference queue kept in the bench. Random traffic biased toward a full queue, with error resets and receiver resets mixed in, also makes an overrun and an error reset coincide. The bench checks that the overrun flag stays set in that case.

// File: rtl/rxq_pkg.sv
// Shared types for the receive queue: one slot holds a character and its flags.
package rxq_pkg;
    localparam int DATA_W = 8;
    localparam int FLAG_W = 3;

    // Flag order: {break, framing error, parity error}
    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
// Ring-buffer storage with occupancy tracking.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// clear empties the storage and takes priority over push and pop.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       wr_en,
    input  logic       rd_en,
    input  rxq_entry_t wr_ent,
    output rxq_entry_t head,
    output logic       empty,
    output logic       is_full,
    output logic       accept,
    output logic       drop
);
    rxq_entry_t      mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic [CW-1:0]   count;
    logic            pop;

    // Decide which of this cycle's requests take effect
    always_comb begin
        empty   = (count == '0);
        is_full = (count == CW'(DEPTH));
        pop     = rd_en && !empty && !clear;
        accept  = wr_en && !clear && (!is_full || rd_en);
        drop    = wr_en && !clear && is_full && !rd_en;
        head    = mem[rptr];
    end

    // Write the accepted character into its slot
    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_ent;
    end

    // Advance the pointers and the occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (accept) wptr <= wptr + 1'b1;
            if (pop)    rptr <= rptr + 1'b1;
            case ({accept, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !empty && !wr_en && !clear) |=> (count == $past(count) - 1'b1));
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_en && !rd_en && !clear) |=> (is_full && $stable(wptr) && $stable(rptr)));
    a_r8_swap_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_en && rd_en && !clear) |=> is_full);
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> empty);
endmodule

// File: rtl/rxq_status.sv
// Builds the reported error flags, the sticky overrun flag and the interrupt.
// Assumes accept and drop come from rxq_store for the same cycle.
module rxq_status
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              drop,
    input  logic [FLAG_W-1:0] new_flags,
    input  logic [FLAG_W-1:0] head_flags,
    input  logic              ready,
    input  logic              is_full,
    input  logic              block_mode,
    input  logic              err_reset,
    input  logic              irq_sel_full,
    output logic [FLAG_W-1:0] stat,
    output logic              overrun,
    output logic              irq
);
    logic [FLAG_W-1:0] acc;
    logic [FLAG_W-1:0] in_flags;

    // Flags that the accumulator takes in this cycle
    always_comb in_flags = accept ? new_flags : '0;

    // Accumulate flags of accepted characters; err_reset restarts the OR
    always_ff @(posedge clk) begin
        if (!rst_n)         acc <= '0;
        else if (err_reset) acc <= in_flags;
        else                acc <= acc | in_flags;
    end

    // Sticky overrun: a new loss wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)         overrun <= 1'b0;
        else if (drop)      overrun <= 1'b1;
        else if (err_reset) overrun <= 1'b0;
    end

    // Select the status view and the interrupt source
    always_comb begin
        stat = ready ? (block_mode ? acc : head_flags) : '0;
        irq  = irq_sel_full ? is_full : ready;
    end

    a_r6_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> overrun);
    a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_reset) |=> overrun);
    a_r5_acc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !err_reset |=> ((acc & $past(acc)) == $past(acc)));
endmodule

// File: rtl/rx_status_fifo.sv
// Receive queue between a serial receiver and a CPU read port.
// Each slot keeps the character plus parity, framing and break flags.
// Assumes DEPTH is 8 or 16 and that rd_en lasts one cycle per character read.
module rx_status_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rcv_reset,
    input  logic       err_reset,
    input  logic       block_mode,
    input  logic       irq_sel_full,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_perr,
    input  logic       wr_ferr,
    input  logic       wr_brk,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       ready,
    output logic       full,
    output logic       stat_perr,
    output logic       stat_ferr,
    output logic       stat_brk,
    output logic       overrun,
    output logic       irq
);
    rxq_entry_t        wr_ent, head;
    logic              empty, is_full, accept, drop;
    logic [FLAG_W-1:0] stat;

    // Pack the incoming character and its flags into one slot
    always_comb begin
        wr_ent.data  = wr_data;
        wr_ent.flags = {wr_brk, wr_ferr, wr_perr};
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rcv_reset),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .wr_ent  (wr_ent),
        .head    (head),
        .empty   (empty),
        .is_full (is_full),
        .accept  (accept),
        .drop    (drop)
    );

    rxq_status u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept       (accept),
        .drop         (drop),
        .new_flags    (wr_ent.flags),
        .head_flags   (head.flags),
        .ready        (!empty),
        .is_full      (is_full),
        .block_mode   (block_mode),
        .err_reset    (err_reset),
        .irq_sel_full (irq_sel_full),
        .stat         (stat),
        .overrun      (overrun),
        .irq          (irq)
    );

    // Drive the outward flags
    always_comb begin
        rd_data   = head.data;
        ready     = !empty;
        full      = is_full;
        stat_perr = stat[0];
        stat_ferr = stat[1];
        stat_brk  = stat[2];
    end

    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sel_full ? (irq == full) : (irq == ready));
endmodule

// File: tb/sim_rx_status_fifo.sv
module sim_rx_status_fifo;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rcv_reset = 0, err_reset = 0, block_mode = 0, irq_sel_full = 0;
    logic wr_en = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0, rd_en = 0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic ready, full, stat_perr, stat_ferr, stat_brk, overrun, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state: each item is {brk, ferr, perr, data}
    logic [10:0] q[$];
    logic [2:0]  acc_m = '0;
    logic        ovr_m = 1'b0;

    always #2.5 clk = ~clk;

    rx_status_fifo #(.DEPTH(D)) u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_stat();
        if (q.size() == 0) return 3'b000;
        return block_mode ? acc_m : q[0][10:8];
    endfunction

    // Apply the current inputs to the reference state (called after a posedge)
    function automatic void model_step();
        logic acc_ok, drp;
        logic [2:0] nf;
        nf = {wr_brk, wr_ferr, wr_perr};
        if (rcv_reset) begin
            acc_ok = 0; drp = 0;
            q.delete();
        end else begin
            acc_ok = wr_en && (q.size() < D || rd_en);
            drp    = wr_en && q.size() == D && !rd_en;
            if (rd_en && q.size() > 0) void'(q.pop_front());
            if (acc_ok) q.push_back({nf, wr_data});
        end
        if (err_reset) acc_m = acc_ok ? nf : 3'b000;
        else if (acc_ok) acc_m = acc_m | nf;
        if (drp) ovr_m = 1'b1;
        else if (err_reset) ovr_m = 1'b0;
    endfunction

    // Compare every output against the reference (called at a negedge)
    task automatic check_all();
        chk("R2 ready", ready, q.size() > 0);
        chk("R2 full", full, q.size() == D);
        if (q.size() > 0) chk("R3 rd_data", rd_data, q[0][7:0]);
        chk(block_mode ? "R5 status" : "R4 status",
            {stat_brk, stat_ferr, stat_perr}, exp_stat());
        chk("R6/R7 overrun", overrun, ovr_m);
        chk("R9 irq", irq, irq_sel_full ? (q.size() == D) : (q.size() > 0));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
        {rcv_reset, err_reset, wr_en, rd_en} = '0;
    endtask

    task automatic push(logic [7:0] d, logic [2:0] f);
        wr_en = 1; wr_data = d; {wr_brk, wr_ferr, wr_perr} = f;
        cyc();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 ready", ready, 0);
        chk("R1 full", full, 0);
        chk("R1 status", {stat_brk, stat_ferr, stat_perr}, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 irq", irq, 0);

        // R3 read on empty has no effect
        rd_en = 1; cyc();
        chk("R3 empty read", ready, 0);

        // Fill to full with distinct flags; R4 head flags
        for (int i = 0; i < D; i++) push(8'(i + 8'h40), 3'(i));
        chk("R2 full after fill", full, 1);
        chk("R4 head flags", {stat_brk, stat_ferr, stat_perr}, 3'b000);

        // R8 simultaneous read and write while full
        wr_en = 1; rd_en = 1; wr_data = 8'hA5; {wr_brk, wr_ferr, wr_perr} = 3'b101;
        cyc();
        chk("R8 still full", full, 1);
        chk("R8 no overrun", overrun, 0);
        chk("R8 new head", rd_data, 8'h41);

        // R6 write while full: overrun, contents kept
        push(8'hEE, 3'b111);
        chk("R6 overrun set", overrun, 1);
        chk("R6 head unchanged", rd_data, 8'h41);

        // R9 irq select
        irq_sel_full = 1; #1;
        chk("R9 irq full", irq, 1);

        // R5 block mode shows OR of all accepted flags
        block_mode = 1; #1;
        chk("R5 block OR", {stat_brk, stat_ferr, stat_perr}, 3'b111);

        // R7 err_reset together with a new overrun keeps overrun set
        err_reset = 1; wr_en = 1; wr_data = 8'h11; cyc();
        chk("R7 overrun set wins", overrun, 1);
        err_reset = 1; cyc();
        chk("R7 overrun cleared", overrun, 0);
        chk("R5 cleared block", {stat_brk, stat_ferr, stat_perr}, 0);

        // Drain and verify order (R3)
        for (int i = 0; i < D; i++) begin
            rd_en = 1; cyc();
        end
        chk("R3 drained", ready, 0);

        // R10 receiver reset wins over a same-cycle write
        push(8'h01, 3'b010);
        rcv_reset = 1; wr_en = 1; wr_data = 8'h02; cyc();
        chk("R10 emptied", ready, 0);
        chk("R10 overrun kept", overrun, 0);

        // Random traffic, biased to fill the queue part of the time
        for (int n = 0; n < 6000; n++) begin
            int bias;
            bias = ((n / 500) % 2 == 0) ? 80 : 35;
            wr_en     = ($urandom_range(99) < bias);
            rd_en     = ($urandom_range(99) < 50);
            err_reset = ($urandom_range(99) < 4);
            rcv_reset = ($urandom_range(99) < 1);
            wr_data   = 8'($urandom);
            {wr_brk, wr_ferr, wr_perr} = 3'($urandom_range(7) == 0 ? $urandom : 0);
            if ($urandom_range(99) < 3) block_mode = ~block_mode;
            if ($urandom_range(99) < 3) irq_sel_full = ~irq_sel_full;
            cyc();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule